// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

The controller gathers 64 level-sensitive interrupt lines and turns them into a single outstanding request for the processor. The request is a valid flag with a 6-bit interrupt number. Lines 0 to 31 come from expansion-bus slots. They are gated in groups of four by eight shared mapping registers. Lines 32 to 63 come from on-board peripherals, and each of them has its own mapping register. Bit 31 of every mapping register is the enable bit.

When no request is outstanding, the block scans the latched, enabled lines from number 0 upward and raises the lowest one. The request then stays in place, unchanged, until software retires it. Software can retire it in three ways:
- by disabling the mapping register that covers the pending number;
- by writing the slot clear register of the pending number's group of four;
- by writing the on-board clear register whose number matches the pending number exactly.

In the cycle after a request is retired, the block scans the lines again. A line that is still asserted and still enabled is therefore requested again without needing a new edge.

Top module: `irq_vector_ctl`

## Requirements
- R1: Interrupt number n, for n from 0 to 31, is slot line `irq_lvl[n]`, and its enable is slot mapping register n/4. Number n, for n from 32 to 63, is on-board line `irq_lvl[n]`, and its enable is on-board mapping register n-32. `req_num` carries the number as an unsigned 6-bit value.
- R2: The block may be idle with an enabled line asserted. Given those conditions, the line is sampled at one rising edge and `req_valid` rises at the next rising edge. When several enabled lines are asserted, the lowest number is presented.
- R3: A presented request keeps `req_valid` high and `req_num` unchanged until one of the retire writes in R5, R6 or R7 occurs. This holds even if the line drops, and even if other lines rise.
- R4: Slot mapping register g (g from 0 to 7) sits at byte address 0xC00+8g. On-board mapping register j (j from 0 to 31) sits at 0x1000+8j. A write changes only bit 31, the enable bit. A read returns bit 31 = enable, bits 30:11 = 0, and bits 10:0 = 0x7C0 OR 4g (slot) or 0x7E0 + j (on-board).
- R5: A mapping-register write with bit 31 = 0 retires the pending request if that register covers the pending number. A write to a register that does not cover it has no effect on the request.
- R6: A write to slot clear register g, at 0x1400+32g, retires the pending request only when the pending number divided by 4 equals g.
- R7: A write to on-board clear register j, at 0x1800+8j, retires the pending request only when the pending number equals 32+j.
- R8: After a retire write, `req_valid` is low for exactly one cycle. It then rises again with the lowest enabled, still-asserted line, if one exists.
- R9: Reset clears every enable bit, returns the request to idle, clears the latched line levels, and leaves bits 10:0 of the mapping registers unchanged.
- R10: Reads of any other address return 0, and so do reads of the clear registers. Writes to any other address have no effect.
- R11: While `req_valid` is low, `req_num` is 0.
- R12: A read with `reg_rd_en` high at a rising edge puts the data on `reg_rdata` after that edge. `reg_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl | input | 64 | Interrupt line levels, one bit per interrupt number |
| reg_addr | input | 16 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | A request is outstanding |
| req_num | output | 6 | Number of the outstanding request |

## Verification
A retire write can land in the same cycle as a line change. The bench provokes this in two ways:
- It drops the pending line, or leaves it asserted, at the edge where a clear is written, with a lower and a higher line also asserted.
- It writes a clear that only nearly matches the pending number: the wrong slot group, or a neighbouring on-board number.

Each case is judged at the port on the two cycles after the write. In the first cycle `req_valid` must be low; in the second, `req_num` must be the lowest line that is still eligible. Where the clear does not match, the same request must simply stay in place.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       irq_lvl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd_en,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  output logic [5:0]        req_num
);
  localparam int NSRC = 64;
  localparam int NGRP = 8;
  localparam int NOB  = 32;
  localparam int ENB  = DATA_W - 1;

  logic [NSRC-1:0] lvl_q;
  logic [NGRP-1:0] grp_en;
  logic [NOB-1:0]  ob_en;
  logic [NSRC-1:0] en_vec, elig;
  logic            pend;
  logic [5:0]      pnum;
  logic [5:0]      pick;
  logic            any;
  logic [DATA_W-1:0] rd_val;

  wire       map_g_hit = reg_addr[15:6] == 10'h030 && reg_addr[2:0] == 3'd0;
  wire       map_o_hit = reg_addr[15:8] == 8'h10 && reg_addr[2:0] == 3'd0;
  wire       clr_g_hit = reg_addr[15:8] == 8'h14 && reg_addr[4:0] == 5'd0;
  wire       clr_o_hit = reg_addr[15:8] == 8'h18 && reg_addr[2:0] == 3'd0;
  wire [2:0] g_idx     = reg_addr[5:3];
  wire [4:0] o_idx     = reg_addr[7:3];
  wire [2:0] cg_idx    = reg_addr[7:5];
  wire       wen       = reg_wdata[ENB];

  wire retire = pend && reg_wr_en && (
      (map_g_hit && !wen && !pnum[5] && pnum[4:2] == g_idx) ||
      (map_o_hit && !wen && pnum == {1'b1, o_idx}) ||
      (clr_g_hit && pnum[5:2] == {1'b0, cg_idx}) ||
      (clr_o_hit && pnum == {1'b1, o_idx}));

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      en_vec[i] = (i < NGRP*4) ? grp_en[i/4] : ob_en[i - NGRP*4];
  end

  assign elig = lvl_q & en_vec;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NSRC-1; i >= 0; i--)
      if (elig[i]) begin
        pick = 6'(i);
        any  = 1'b1;
      end
  end

  always_comb begin
    rd_val = '0;
    if (map_g_hit)
      rd_val = {grp_en[g_idx], 20'd0, 11'h7C0 | {6'd0, g_idx, 2'b00}};
    else if (map_o_hit)
      rd_val = {ob_en[o_idx], 20'd0, 11'h7E0 | {6'd0, o_idx}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      grp_en <= '0;
      ob_en  <= '0;
      pend   <= 1'b0;
      pnum   <= '0;
    end else begin
      lvl_q <= irq_lvl;
      if (reg_wr_en && map_g_hit) grp_en[g_idx] <= wen;
      if (reg_wr_en && map_o_hit) ob_en[o_idx]  <= wen;
      if (pend) begin
        if (retire) begin
          pend <= 1'b0;
          pnum <= '0;
        end
      end else if (any) begin
        pend <= 1'b1;
        pnum <= pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_val;
  end

  assign req_valid = pend;
  assign req_num   = pnum;
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] irq_lvl,
  input logic        reg_wr_en,
  input logic        req_valid,
  input logic [5:0]  req_num
);
  logic [63:0] lvl_d1, lvl_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d1 <= '0;
      lvl_d2 <= '0;
    end else begin
      lvl_d1 <= irq_lvl;
      lvl_d2 <= lvl_d1;
    end
  end

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reg_wr_en) |=> (req_valid && $stable(req_num)));

  a_r11_idle_num_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_num == 6'd0);

  a_r2_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> lvl_d2[req_num]);

  a_r5_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_valid) |-> $past(reg_wr_en));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .reg_wr_en(reg_wr_en),
  .req_valid(req_valid), .req_num(req_num)
);

// File: tb/irq_vector_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lvl = '0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [5:0]  req_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irq_vector_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_num(req_num)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_req(string req, logic v, logic [5:0] n);
    check({req, " valid"}, {31'd0, req_valid}, {31'd0, v});
    check({req, " num"}, {26'd0, req_num}, {26'd0, n});
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [15:0] a, logic [31:0] exp);
    reg_addr = a; reg_rd_en = 1'b1;
    step();
    reg_rd_en = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic t_reset_state;
    check_req("R9 reset request", 1'b0, 6'd0);
    rd_check("R9 reset slot map0", 16'h0C00, 32'h0000_07C0);
    rd_check("R9 reset board map5", 16'h1028, 32'h0000_07E5);
    rd_check("R4 slot map7 low bits", 16'h0C38, 32'h0000_07DC);
  endtask

  task automatic t_map_write;
    wr(16'h0C08, 32'hFFFF_FFFF);
    rd_check("R4 slot map1 only enable", 16'h0C08, 32'h8000_07C4);
    wr(16'h1018, 32'h8000_0000);
    rd_check("R4 board map3 enable", 16'h1018, 32'h8000_07E3);
    step();
    check("R12 rdata held", reg_rdata, 32'h8000_07E3);
  endtask

  task automatic t_basic_request;
    irq_lvl[5] = 1'b1;
    step();
    check_req("R2 not yet after one edge", 1'b0, 6'd0);
    step();
    check_req("R2 raised line 5", 1'b1, 6'd5);
    irq_lvl[5] = 1'b0;
    irq_lvl[4] = 1'b1;
    step(3);
    check_req("R3 held after line drop", 1'b1, 6'd5);
    irq_lvl[4] = 1'b0;
    step();
    wr(16'h1400, 32'h0);
    check_req("R6 wrong group keeps", 1'b1, 6'd5);
    wr(16'h1420, 32'h0);
    check_req("R6 group clear retires", 1'b0, 6'd0);
    step(2);
    check_req("R8 nothing left to raise", 1'b0, 6'd0);
  endtask

  task automatic t_priority;
    wr(16'h0C00, 32'h8000_0000);
    irq_lvl[35] = 1'b1; irq_lvl[2] = 1'b1; irq_lvl[6] = 1'b1;
    step(2);
    check_req("R2 lowest wins", 1'b1, 6'd2);
    wr(16'h1400, 32'h0);
    check_req("R8 gap after clear", 1'b0, 6'd0);
    step();
    check_req("R8 re-request still asserted", 1'b1, 6'd2);
    irq_lvl[2] = 1'b0;
    wr(16'h1400, 32'h0);
    check_req("R8 gap same-cycle drop", 1'b0, 6'd0);
    step();
    check_req("R8 next lowest 6", 1'b1, 6'd6);
    irq_lvl[6] = 1'b0;
    wr(16'h1420, 32'h0);
    step();
    check_req("R1 board line numbered 35", 1'b1, 6'd35);
    wr(16'h1820, 32'h0);
    check_req("R7 neighbour clear keeps", 1'b1, 6'd35);
    wr(16'h0C00, 32'h0);
    check_req("R5 non-covering disable keeps", 1'b1, 6'd35);
    wr(16'h1818, 32'h0);
    check_req("R7 exact clear retires", 1'b0, 6'd0);
    step();
    check_req("R8 board re-request", 1'b1, 6'd35);
    wr(16'h1018, 32'h0);
    check_req("R5 covering disable retires", 1'b0, 6'd0);
    step(2);
    check_req("R5 disabled not re-raised", 1'b0, 6'd0);
    irq_lvl[35] = 1'b0;
    irq_lvl[40] = 1'b1;
    step(3);
    check_req("R1 disabled board line ignored", 1'b0, 6'd0);
    irq_lvl[40] = 1'b0;
  endtask

  task automatic t_unmapped;
    wr(16'h2000, 32'hFFFF_FFFF);
    wr(16'h0C04, 32'hFFFF_FFFF);
    rd_check("R10 unmapped read zero", 16'h2000, 32'h0);
    rd_check("R10 clear reg reads zero", 16'h1420, 32'h0);
    rd_check("R10 misaligned read zero", 16'h0C04, 32'h0);
    rd_check("R10 misaligned write ignored", 16'h0C00, 32'h0000_07C0);
  endtask

  task automatic t_reset_mid;
    irq_lvl[7] = 1'b1;
    step(2);
    check_req("R2 group1 line 7", 1'b1, 6'd7);
    rst_n = 1'b0;
    step();
    check_req("R9 reset drops request", 1'b0, 6'd0);
    rst_n = 1'b1;
    step(3);
    check_req("R9 enables cleared", 1'b0, 6'd0);
    rd_check("R9 slot map1 after reset", 16'h0C08, 32'h0000_07C4);
    irq_lvl[7] = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_map_write();
    t_basic_request();
    t_priority();
    t_unmapped();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule